// File: doc/BRIEF.md
# Register Window Address Translator

This block sits in front of an 8-bit directly addressed register file. It maps a slice of higher memory, somewhere in the range 1800h–1FFFh, onto the upper part of the direct address space. The slice is chosen by an 8-bit selection value. The selection value sets both the size of the slice (32, 64 or 128 bytes) and its physical base. Each access cycle, the block takes the direct address and the strobes and decides whether the access lands inside the active window. It then produces the 16-bit physical address that the memory fabric should use.

The physical page 1FE0h–1FFFh must never be reachable through a window. When a windowed access lands there, the block raises a blocked flag and gates both memory strobes. It also forces the returned read data to FFh. Any access that falls outside the window passes straight to 0000h–00FFh with its address unchanged. The whole path is combinational, so a new selection value applies from the next access onward.

Top module: `reg_window_xlate`

## Requirements
- R1: Selection values 40h–7Fh open a 32-byte window over direct addresses E0h–FFh. The physical address is 1800h + sel[5:0]·32 + (dir − E0h), and win_hit is 1.
- R2: Selection values 20h–3Fh open a 64-byte window over direct addresses C0h–FFh. The physical address is 1800h + sel[4:0]·64 + (dir − C0h), and win_hit is 1.
- R3: Selection values 10h–1Fh open a 128-byte window over direct addresses 80h–FFh. The physical address is 1800h + sel[3:0]·128 + (dir − 80h), and win_hit is 1.
- R4: Selection values 00h–0Fh and 80h–FFh open no window. For every direct address, phys_addr = {00h, dir} and win_hit = 0.
- R5: A direct address below the start of the active window gives phys_addr = {00h, dir} and win_hit = 0.
- R6: blocked is 1 exactly when win_hit is 1 and phys_addr lies in 1FE0h–1FFFh. While blocked is 1, mem_rd and mem_wr are 0 and rd_data is FFh.
- R7: While blocked is 0, mem_rd equals rd_en, mem_wr equals wr_en, and rd_data equals mem_rdata.
- R8: All outputs depend only on the present inputs. Changing the selection value between two consecutive access cycles changes the translation in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_addr | input | 8 | Direct register address of the access |
| win_sel | input | 8 | Current window selection value |
| rd_en | input | 1 | Read strobe from the core |
| wr_en | input | 1 | Write strobe from the core |
| mem_rdata | input | 8 | Read data returned by the memory fabric |
| phys_addr | output | 16 | Translated physical address |
| win_hit | output | 1 | Access falls inside the active window |
| blocked | output | 1 | Windowed access targets the protected page |
| mem_rd | output | 1 | Read strobe forwarded to memory |
| mem_wr | output | 1 | Write strobe forwarded to memory |
| rd_data | output | 8 | Read data returned to the core |

## Verification
The bench sweeps every pairing of selection value and direct address, so every size-class boundary is exercised. This covers the 0Fh/10h, 1Fh/20h, 3Fh/40h and 7Fh/80h selection edges and the 7Fh/80h, BFh/C0h and DFh/E0h address edges. A design that decoded a size class off by one would map a whole group of selections to the wrong base. A design that compared the window start wrongly would either leak low registers into high memory or hide the lowest window byte. Selections 7Fh, 3Fh and 1Fh each reach the protected page, through all of the window or only through its top 32 bytes. A design that checked the direct address instead of the physical one, or that forgot to gate the strobes, would let writes through or return real data there. A back-to-back change of selection with a fixed address confirms that no stale translation is held.

// File: rtl/reg_window_xlate.sv
module reg_window_xlate #(
  parameter logic [15:0] WIN_BASE = 16'h1800,
  parameter logic [15:0] PROT_LO  = 16'h1FE0,
  parameter logic [15:0] PROT_HI  = 16'h1FFF
) (
  input  logic [7:0]  dir_addr,
  input  logic [7:0]  win_sel,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] phys_addr,
  output logic        win_hit,
  output logic        blocked,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  rd_data
);

  logic [7:0]  win_start;
  logic [15:0] win_base;
  logic        win_on;

  always_comb begin
    win_on    = 1'b1;
    win_start = 8'hE0;
    win_base  = WIN_BASE;
    unique case (win_sel[7:4])
      4'h4, 4'h5, 4'h6, 4'h7: begin
        win_start = 8'hE0;
        win_base  = WIN_BASE + {5'b0, win_sel[5:0], 5'b0};
      end
      4'h2, 4'h3: begin
        win_start = 8'hC0;
        win_base  = WIN_BASE + {5'b0, win_sel[4:0], 6'b0};
      end
      4'h1: begin
        win_start = 8'h80;
        win_base  = WIN_BASE + {5'b0, win_sel[3:0], 7'b0};
      end
      default: win_on = 1'b0;
    endcase
  end

  assign win_hit   = win_on && (dir_addr >= win_start);
  assign phys_addr = win_hit ? win_base + {8'h00, dir_addr - win_start} : {8'h00, dir_addr};
  assign blocked   = win_hit && (phys_addr >= PROT_LO) && (phys_addr <= PROT_HI);
  assign mem_rd    = rd_en & ~blocked;
  assign mem_wr    = wr_en & ~blocked;
  assign rd_data   = blocked ? 8'hFF : mem_rdata;

  always_comb begin
    if (!$isunknown({dir_addr, win_sel, rd_en, wr_en, mem_rdata})) begin
      AST_HIT_TOP_ONLY: assert (!win_hit || dir_addr[7]);  // R5
      AST_PASS_LOW: assert (win_hit || phys_addr == {8'h00, dir_addr});  // R4
      AST_PROT_NO_WR: assert (!(win_hit && phys_addr >= PROT_LO) || !mem_wr);  // R6
      AST_PROT_RD_FF: assert (!(blocked && rd_en) || rd_data == 8'hFF);  // R6
      AST_HIT_RANGE: assert (!win_hit || (phys_addr >= WIN_BASE && phys_addr <= PROT_HI));  // R1
      AST_STROBE_PASS: assert (blocked || (mem_wr == wr_en && mem_rd == rd_en));  // R7
    end
  end

endmodule

// File: tb/tb_reg_window_xlate.sv
`timescale 1ns/1ps
module tb_reg_window_xlate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  dir_addr = '0, win_sel = '0, mem_rdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] phys_addr;
  logic        win_hit, blocked, mem_rd, mem_wr;
  logic [7:0]  rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  reg_window_xlate dut (
    .dir_addr(dir_addr), .win_sel(win_sel), .rd_en(rd_en), .wr_en(wr_en),
    .mem_rdata(mem_rdata), .phys_addr(phys_addr), .win_hit(win_hit),
    .blocked(blocked), .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_data(rd_data)
  );

  function automatic void model(input logic [7:0] s, input logic [7:0] a,
                                output logic [15:0] p, output logic h,
                                output logic b, output string tag);
    logic [7:0]  st;
    logic [15:0] base;
    bit on;
    on = 1; st = 8'hE0; base = 16'h1800; tag = "R4";
    if (s >= 8'h40 && s <= 8'h7F) begin
      st = 8'hE0; base = 16'h1800 + 16'(s[5:0]) * 16'd32; tag = "R1";
    end else if (s >= 8'h20 && s <= 8'h3F) begin
      st = 8'hC0; base = 16'h1800 + 16'(s[4:0]) * 16'd64; tag = "R2";
    end else if (s >= 8'h10 && s <= 8'h1F) begin
      st = 8'h80; base = 16'h1800 + 16'(s[3:0]) * 16'd128; tag = "R3";
    end else on = 0;
    h = on && (a >= st);
    if (on && !h) tag = "R5";
    p = h ? base + 16'(a - st) : {8'h00, a};
    b = h && (p >= 16'h1FE0);
    if (b) tag = "R6";
  endfunction

  task automatic check_addr(input string tag);
    logic [15:0] ep; logic eh, eb; string t;
    model(win_sel, dir_addr, ep, eh, eb, t);
    n_chk++;
    if (phys_addr !== ep || win_hit !== eh || blocked !== eb) begin
      n_bad++;
      $display("FAIL %s sel=%h dir=%h phys/hit/blk=%h/%b/%b expected %h/%b/%b",
               (tag == "") ? t : tag, win_sel, dir_addr, phys_addr, win_hit, blocked, ep, eh, eb);
    end
  endtask

  task automatic check_strobes();
    logic [15:0] ep; logic eh, eb; string t;
    logic erd, ewr; logic [7:0] edat;
    model(win_sel, dir_addr, ep, eh, eb, t);
    erd  = eb ? 1'b0 : rd_en;
    ewr  = eb ? 1'b0 : wr_en;
    edat = eb ? 8'hFF : mem_rdata;
    n_chk++;
    if (mem_rd !== erd || mem_wr !== ewr || rd_data !== edat) begin
      n_bad++;
      $display("FAIL %s sel=%h dir=%h rd/wr/data=%b/%b/%h expected %b/%b/%h",
               eb ? "R6" : "R7", win_sel, dir_addr, mem_rd, mem_wr, rd_data, erd, ewr, edat);
    end
  endtask

  task automatic drive(input logic [7:0] s, input logic [7:0] a, input logic r, input logic w);
    @(posedge clk); #1;
    win_sel = s; dir_addr = a; rd_en = r; wr_en = w; mem_rdata = a ^ s ^ 8'h5A;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (phys_addr !== 16'h0000 || win_hit !== 1'b0 || blocked !== 1'b0 || mem_wr !== 1'b0) begin
      n_bad++;
      $display("FAIL R4 idle state phys=%h hit=%b blk=%b wr=%b expected 0000/0/0/0",
               phys_addr, win_hit, blocked, mem_wr);
    end
    for (int s = 0; s < 256; s++) begin
      for (int a = 0; a < 256; a++) begin
        logic [1:0] pat;
        pat = 2'((s ^ a ^ (a >> 2)) & 3);
        drive(8'(s), 8'(a), pat[0], pat[1]);
        check_addr("");
        check_strobes();
      end
    end
    // R8: selection change on back-to-back cycles with fixed address
    drive(8'h7B, 8'hE5, 1'b1, 1'b0);
    n_chk++;
    if (phys_addr !== 16'h1F65) begin
      n_bad++; $display("FAIL R8 phys=%h expected 1f65", phys_addr);
    end
    drive(8'h3C, 8'hE5, 1'b0, 1'b1);
    n_chk++;
    if (phys_addr !== 16'h1F25) begin
      n_bad++; $display("FAIL R8 phys=%h expected 1f25", phys_addr);
    end
    drive(8'h1F, 8'hE5, 1'b0, 1'b1);
    check_addr("R8");
    check_strobes();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule